// File: doc/BRIEF.md
# Programmable PN Matched Filter Correlator

This block despreads a direct-sequence spread-spectrum signal. Baseband samples arrive at two per chip. An optional front-end stage adds each consecutive pair of samples to form one chip value. Each chip value enters a 64-stage delay line. On every chip, the contents of the delay line are correlated against one of two independently programmed ternary coefficient banks. One bank is used for acquisition and the preamble, the other for data symbols.

The block produces a full-width 10-bit correlation result for downstream tracking logic. It also produces an 8-bit scaled copy, which is the correlation divided by a programmable power of two. An 8-bit register port programs the coefficients, the front-end mode and the output scale. Code lengths shorter than 64 are obtained by setting the unused high-numbered taps to zero.

Top module: `pn_corr_top`

## Requirements
- R1: After reset, `corr_vld`, `corr_full` and `corr_win` are zero, and every register address reads back 0x00.
- R2: Acquisition bank register at address 0x07+k (k = 0..15) holds taps 4k..4k+3, with tap 4k+j in bits 2j+1:2j. Data bank registers at 0x17+k use the same packing. Front-end control is at 0x27 and window control at 0x28; each control register stores the whole byte. Every mapped address reads back the byte last written. A write to any other address changes nothing, and such an address reads 0x00. Writing to one bank never changes the other.
- R3: Tap code 01 weighs a chip by +1, code 11 weighs it by -1, and codes 00 and 10 weigh it by 0.
- R4: Tap 0 holds the newest chip, and each new chip moves older chips one tap higher. The correlation is the sum over all taps of chip times tap weight.
- R5: `bank_sel` (0 = acquisition bank, 1 = data bank) is sampled only together with a chip-completing sample. The chosen bank drives every correlation until the next chip is completed.
- R6: With bit 0 of 0x27 at 0, every second valid sample completes a chip whose value is the sum of the two samples. With bit 0 of 0x27 at 1, every valid sample is a chip equal to that sample, and the pairing restarts.
- R7: `corr_vld` is high for exactly the cycle that starts two rising edges after the edge that accepts a chip-completing sample. `corr_full` and `corr_win` change only when `corr_vld` rises.
- R8: `corr_full` is the correlation in two's complement, saturated to -512..511.
- R9: Bits 1:0 of 0x28 give n. `corr_win` equals floor(`corr_full` / 2^n), saturated to -128..127.
- R10: Taps programmed to zero contribute nothing, so a code of length N is correlated by programming taps N..63 to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data for `cfg_addr` (combinational) |
| smp_vld | input | 1 | Input sample valid |
| smp_data | input | 3 | Input sample, two's complement |
| bank_sel | input | 1 | Coefficient bank request: 0 acquisition, 1 data |
| corr_vld | output | 1 | One-cycle strobe marking a new correlation result |
| corr_full | output | 10 | Saturated full-width correlation |
| corr_win | output | 8 | Scaled and saturated 8-bit correlation |

## Verification
The bench builds the block with its default parameters: 64 taps, 3-bit samples, a 10-bit result and an 8-bit window. The register map depends on these values, so no smaller configuration would keep the addresses meaningful. It sweeps all eight sample values against all four tap codes, every register address for readback, and all four window shifts at both saturation extremes. Random ±1 codes in both banks, random bank switching in the middle of sample pairs, and a shortened 13-tap code are checked against an arithmetic model of the delay line.

// File: rtl/pn_corr_pkg.sv
`timescale 1ns/1ps
package pn_corr_pkg;

  typedef enum logic [1:0] {
    TW_ZERO = 2'd0,
    TW_POS  = 2'd1,
    TW_NEG  = 2'd2
  } tap_wt_e;

  // Ternary tap code: bit 0 enables the tap, bit 1 selects the negative sign.
  function automatic tap_wt_e decode_tap(input logic [1:0] code);
    if (!code[0])     return TW_ZERO;
    else if (code[1]) return TW_NEG;
    else              return TW_POS;
  endfunction

  function automatic int clamp_int(input int v, input int lo, input int hi);
    if (v > hi)      return hi;
    else if (v < lo) return lo;
    else             return v;
  endfunction

  // Scaled window: floor division by 2^n, then clamp.
  function automatic int window_int(input int full, input int n, input int lo, input int hi);
    return clamp_int(full >>> n, lo, hi);
  endfunction

endpackage

// File: rtl/pn_corr_regs.sv
`timescale 1ns/1ps
module pn_corr_regs #(
  parameter int NTAPS    = 64,
  parameter int AW       = 6,
  parameter int ACQ_BASE = 7,
  parameter int DAT_BASE = 23,
  parameter int FE_ADDR  = 39,
  parameter int WIN_ADDR = 40
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [2*NTAPS-1:0]   acq_coef,
  output logic [2*NTAPS-1:0]   dat_coef,
  output logic                 fe_bypass,
  output logic [1:0]           win_sel
);
  localparam int NREG = NTAPS / 4;

  logic [7:0] acq_q [NREG];
  logic [7:0] dat_q [NREG];
  logic [7:0] fe_q;
  logic [7:0] win_q;

  logic [NREG-1:0] acq_hit;
  logic [NREG-1:0] dat_hit;
  logic            fe_hit;
  logic            win_hit;

  assign fe_hit  = (addr == AW'(FE_ADDR));
  assign win_hit = (addr == AW'(WIN_ADDR));

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    assign acq_hit[r] = (addr == AW'(ACQ_BASE + r));
    assign dat_hit[r] = (addr == AW'(DAT_BASE + r));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acq_q[r] <= '0;
        dat_q[r] <= '0;
      end else if (we) begin
        if (acq_hit[r]) acq_q[r] <= wdata;
        if (dat_hit[r]) dat_q[r] <= wdata;
      end
    end

    assign acq_coef[8*r +: 8] = acq_q[r];
    assign dat_coef[8*r +: 8] = dat_q[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fe_q  <= '0;
      win_q <= '0;
    end else if (we) begin
      if (fe_hit)  fe_q  <= wdata;
      if (win_hit) win_q <= wdata;
    end
  end

  assign fe_bypass = fe_q[0];
  assign win_sel   = win_q[1:0];

  always_comb begin
    rdata = '0;
    for (int r = 0; r < NREG; r++) begin
      if (acq_hit[r]) rdata = acq_q[r];
      if (dat_hit[r]) rdata = dat_q[r];
    end
    if (fe_hit)  rdata = fe_q;
    if (win_hit) rdata = win_q;
  end

endmodule

// File: rtl/pn_corr_fe.sv
`timescale 1ns/1ps
module pn_corr_fe #(
  parameter int SAMP_W = 3,
  parameter int CHIP_W = SAMP_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bypass,
  input  logic                     s_vld,
  input  logic [SAMP_W-1:0]        s_data,
  output logic                     chip_stb,
  output logic signed [CHIP_W-1:0] chip_data
);
  localparam int EXT = CHIP_W - SAMP_W;

  logic                     phase_q;
  logic signed [CHIP_W-1:0] half_q;
  logic signed [CHIP_W-1:0] s_ext;

  assign s_ext = {{EXT{s_data[SAMP_W-1]}}, s_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      half_q  <= '0;
    end else if (bypass) begin
      phase_q <= 1'b0;
    end else if (s_vld) begin
      phase_q <= ~phase_q;
      if (!phase_q) half_q <= s_ext;
    end
  end

  assign chip_stb  = s_vld && (bypass || phase_q);
  assign chip_data = bypass ? s_ext : (half_q + s_ext);

endmodule

// File: rtl/pn_corr_mac.sv
`timescale 1ns/1ps
module pn_corr_mac
  import pn_corr_pkg::*;
#(
  parameter int NTAPS  = 64,
  parameter int CHIP_W = 4,
  parameter int SUM_W  = CHIP_W + $clog2(NTAPS) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    chip_stb,
  input  logic signed [CHIP_W-1:0] chip_data,
  input  logic                    bank_sel,
  input  logic [2*NTAPS-1:0]      acq_coef,
  input  logic [2*NTAPS-1:0]      dat_coef,
  output logic                    line_moved,
  output logic signed [SUM_W-1:0] sum_raw
);
  logic signed [CHIP_W-1:0] line_q [NTAPS];
  logic                     act_bank_q;
  logic [2*NTAPS-1:0]       coef_sel;
  logic signed [SUM_W-1:0]  prod [NTAPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_bank_q <= 1'b0;
      line_moved <= 1'b0;
    end else begin
      line_moved <= chip_stb;
      if (chip_stb) act_bank_q <= bank_sel;
    end
  end

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [SUM_W-1:0] x_ext;
    tap_wt_e                 wt;

    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        line_q[0] <= '0;
        else if (chip_stb) line_q[0] <= chip_data;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        line_q[k] <= '0;
        else if (chip_stb) line_q[k] <= line_q[k-1];
      end
    end

    assign x_ext = SUM_W'(line_q[k]);
    assign wt    = decode_tap(coef_sel[2*k +: 2]);

    always_comb begin
      unique case (wt)
        TW_POS:  prod[k] = x_ext;
        TW_NEG:  prod[k] = -x_ext;
        default: prod[k] = '0;
      endcase
    end
  end

  assign coef_sel = act_bank_q ? dat_coef : acq_coef;

  always_comb begin
    sum_raw = '0;
    for (int k = 0; k < NTAPS; k++) sum_raw = sum_raw + prod[k];
  end

endmodule

// File: rtl/pn_corr_top.sv
`timescale 1ns/1ps
module pn_corr_top
  import pn_corr_pkg::*;
#(
  parameter int NTAPS    = 64,
  parameter int SAMP_W   = 3,
  parameter int FULL_W   = 10,
  parameter int WIN_W    = 8,
  parameter int AW       = 6,
  parameter int ACQ_BASE = 7,
  parameter int DAT_BASE = 23,
  parameter int FE_ADDR  = 39,
  parameter int WIN_ADDR = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              smp_vld,
  input  logic [SAMP_W-1:0] smp_data,
  input  logic              bank_sel,
  output logic              corr_vld,
  output logic [FULL_W-1:0] corr_full,
  output logic [WIN_W-1:0]  corr_win
);
  localparam int CHIP_W   = SAMP_W + 1;
  localparam int SUM_W    = CHIP_W + $clog2(NTAPS) + 1;
  localparam int FULL_MAX = (1 << (FULL_W - 1)) - 1;
  localparam int FULL_MIN = -(1 << (FULL_W - 1));
  localparam int WIN_MAX  = (1 << (WIN_W - 1)) - 1;
  localparam int WIN_MIN  = -(1 << (WIN_W - 1));

  logic [2*NTAPS-1:0]       acq_coef;
  logic [2*NTAPS-1:0]       dat_coef;
  logic                     fe_bypass;
  logic [1:0]               win_sel;
  logic                     chip_stb;
  logic signed [CHIP_W-1:0] chip_data;
  logic                     line_moved;
  logic signed [SUM_W-1:0]  sum_raw;
  logic [FULL_W-1:0]        full_d;
  logic [WIN_W-1:0]         win_d;

  pn_corr_regs #(
    .NTAPS(NTAPS), .AW(AW), .ACQ_BASE(ACQ_BASE), .DAT_BASE(DAT_BASE),
    .FE_ADDR(FE_ADDR), .WIN_ADDR(WIN_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .acq_coef(acq_coef), .dat_coef(dat_coef),
    .fe_bypass(fe_bypass), .win_sel(win_sel)
  );

  pn_corr_fe #(.SAMP_W(SAMP_W), .CHIP_W(CHIP_W)) u_fe (
    .clk(clk), .rst_n(rst_n), .bypass(fe_bypass), .s_vld(smp_vld),
    .s_data(smp_data), .chip_stb(chip_stb), .chip_data(chip_data)
  );

  pn_corr_mac #(.NTAPS(NTAPS), .CHIP_W(CHIP_W), .SUM_W(SUM_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .chip_stb(chip_stb), .chip_data(chip_data),
    .bank_sel(bank_sel), .acq_coef(acq_coef), .dat_coef(dat_coef),
    .line_moved(line_moved), .sum_raw(sum_raw)
  );

  always_comb begin
    int full_i;
    full_i = clamp_int(int'(sum_raw), FULL_MIN, FULL_MAX);
    full_d = FULL_W'(full_i);
    win_d  = WIN_W'(window_int(full_i, int'(win_sel), WIN_MIN, WIN_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_vld  <= 1'b0;
      corr_full <= '0;
      corr_win  <= '0;
    end else begin
      corr_vld <= line_moved;
      if (line_moved) begin
        corr_full <= full_d;
        corr_win  <= win_d;
      end
    end
  end

endmodule

// File: rtl/pn_corr_chk.sv
`timescale 1ns/1ps
module pn_corr_chk #(
  parameter int FULL_W = 10,
  parameter int WIN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_stb,
  input logic              line_moved,
  input logic              fe_bypass,
  input logic              act_bank,
  input logic [1:0]        win_sel,
  input logic              corr_vld,
  input logic [FULL_W-1:0] corr_full,
  input logic [WIN_W-1:0]  corr_win
);
  localparam int WMAX = (1 << (WIN_W - 1)) - 1;
  localparam int WMIN = -(1 << (WIN_W - 1));
  localparam logic [WIN_W-1:0] WMAX_V = WIN_W'(WMAX);
  localparam logic [WIN_W-1:0] WMIN_V = WIN_W'(WMIN);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    chip_stb |=> ##1 corr_vld); // R7

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_moved |=> ($stable(corr_full) && $stable(corr_win))); // R7

  AST_PAIR_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_stb && !fe_bypass) |=> (!chip_stb || fe_bypass)); // R6

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_stb |=> $stable(act_bank)); // R5

  AST_WIN_CLAMP_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_vld && (($signed(corr_full) >>> $past(win_sel)) > WMAX)) |-> (corr_win == WMAX_V)); // R9

  AST_WIN_CLAMP_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_vld && (($signed(corr_full) >>> $past(win_sel)) < WMIN)) |-> (corr_win == WMIN_V)); // R9

endmodule

bind pn_corr_top pn_corr_chk #(.FULL_W(FULL_W), .WIN_W(WIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_stb(chip_stb), .line_moved(line_moved),
  .fe_bypass(fe_bypass), .act_bank(u_mac.act_bank_q), .win_sel(win_sel),
  .corr_vld(corr_vld), .corr_full(corr_full), .corr_win(corr_win)
);

// File: tb/pn_corr_top_tb_top.sv
`timescale 1ns/1ps
module pn_corr_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       smp_vld = 1'b0;
  logic [2:0] smp_data = '0;
  logic       bank_sel = 1'b0;
  logic       corr_vld;
  logic [9:0] corr_full;
  logic [7:0] corr_win;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int mline [64];
  int acq_m [16];
  int dat_m [16];
  int ctl_fe = 0;
  int ctl_win = 0;
  int phase_m = 0;
  int half_m = 0;
  int bank_m = 0;
  int seed = 12345;

  always #2.5 clk = ~clk;

  pn_corr_top dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .smp_vld(smp_vld),
    .smp_data(smp_data), .bank_sel(bank_sel), .corr_vld(corr_vld),
    .corr_full(corr_full), .corr_win(corr_win)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return seed >>> 8;
  endfunction

  function automatic int weight(input int bank, input int k);
    int code;
    code = ((bank != 0 ? dat_m[k/4] : acq_m[k/4]) >> (2*(k%4))) & 3;
    if (code == 1) return 1;
    if (code == 3) return -1;
    return 0;
  endfunction

  function automatic int clampv(input int v, input int lo, input int hi);
    return (v > hi) ? hi : ((v < lo) ? lo : v);
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[5:0]; cfg_wdata = d[7:0];
    @(negedge clk);
    cfg_we = 1'b0;
    if (a >= 7 && a <= 22)  acq_m[a-7] = d & 255;
    if (a >= 23 && a <= 38) dat_m[a-23] = d & 255;
    if (a == 39) begin ctl_fe = d & 255; if ((d & 1) != 0) phase_m = 0; end
    if (a == 40) ctl_win = d & 255;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk);
    cfg_addr = a[5:0];
    #1;
    chk(cfg_rdata == exp[7:0], tag, $sformatf("readback addr %0d", a), int'(cfg_rdata), exp);
  endtask

  task automatic push(input int s, input int bsel, input string tag);
    int done, chip, sum, fexp, wexp;
    @(negedge clk);
    smp_vld = 1'b1; smp_data = s[2:0]; bank_sel = bsel[0];
    done = 0; chip = 0;
    if ((ctl_fe & 1) != 0) begin done = 1; chip = s; end
    else if (phase_m == 0) begin half_m = s; phase_m = 1; end
    else begin chip = half_m + s; phase_m = 0; done = 1; end
    if (done != 0) begin
      for (int k = 63; k > 0; k--) mline[k] = mline[k-1];
      mline[0] = chip;
      bank_m = bsel;
    end
    @(negedge clk);
    smp_vld = 1'b0;
    chk(corr_vld == 1'b0, "R7", "valid one edge after sample", int'(corr_vld), 0);
    @(negedge clk);
    chk(corr_vld == done[0], "R7", "valid two edges after sample", int'(corr_vld), done);
    if (done != 0) begin
      sum = 0;
      for (int k = 0; k < 64; k++) sum += mline[k] * weight(bank_m, k);
      fexp = clampv(sum, -512, 511);
      wexp = clampv(fexp >>> (ctl_win & 3), -128, 127);
      chk($signed(corr_full) == fexp, tag, "corr_full", int'($signed(corr_full)), fexp);
      chk($signed(corr_win) == wexp, "R9", "corr_win", int'($signed(corr_win)), wexp);
    end
  endtask

  task automatic clear_banks();
    for (int r = 0; r < 16; r++) begin wr(7 + r, 0); wr(23 + r, 0); end
  endtask

  task automatic flush(input int bsel);
    int n = ((ctl_fe & 1) != 0) ? 64 : 128;
    for (int i = 0; i < n; i++) push(0, bsel, "R4");
  endtask

  initial begin
    for (int k = 0; k < 64; k++) mline[k] = 0;
    for (int r = 0; r < 16; r++) begin acq_m[r] = 0; dat_m[r] = 0; end
    repeat (3) @(negedge clk);
    chk(corr_vld == 1'b0 && corr_full == 10'd0 && corr_win == 8'd0, "R1", "outputs in reset",
        int'(corr_full), 0);
    rst_n = 1'b1;
    for (int a = 0; a < 64; a++) rd_chk(a, 0, "R1");

    // R2: register map, readback, unmapped writes, bank independence
    for (int r = 0; r < 16; r++) wr(7 + r, (r * 37 + 5) & 255);
    for (int r = 0; r < 16; r++) rd_chk(23 + r, 0, "R2");
    for (int r = 0; r < 16; r++) wr(23 + r, (r * 91 + 200) & 255);
    for (int r = 0; r < 16; r++) rd_chk(7 + r, (r * 37 + 5) & 255, "R2");
    for (int r = 0; r < 16; r++) rd_chk(23 + r, (r * 91 + 200) & 255, "R2");
    wr(39, 254); rd_chk(39, 254, "R2");
    wr(40, 252); rd_chk(40, 252, "R2");
    wr(0, 255); wr(6, 255); wr(41, 255); wr(63, 255);
    rd_chk(0, 0, "R2"); rd_chk(6, 0, "R2"); rd_chk(41, 0, "R2"); rd_chk(63, 0, "R2");
    rd_chk(7, 5, "R2"); rd_chk(38, (15 * 91 + 200) & 255, "R2");
    rd_chk(39, 254, "R2"); rd_chk(40, 252, "R2");

    // R3 / R6: bypass, every sample against every tap code on tap 0
    clear_banks();
    wr(39, 1); wr(40, 0);
    for (int code = 0; code < 4; code++) begin
      wr(7, code);
      for (int s = -4; s < 4; s++) push(s, 0, "R3");
    end

    // R4: single tap at position 5, impulse travels down the line
    wr(7, 0); wr(8, 8'h04);
    push(3, 0, "R4");
    for (int i = 0; i < 8; i++) push(0, 0, "R4");
    wr(8, 0); wr(22, 8'hC0);
    push(-3, 0, "R4");
    for (int i = 0; i < 64; i++) push(0, 0, "R4");

    // R6: pair summing, all sample pairs on tap 0
    wr(22, 0); wr(7, 1); wr(39, 0);
    for (int a = -4; a < 4; a++)
      for (int b = -4; b < 4; b++) begin push(a, 0, "R6"); push(b, 0, "R6"); end

    // R5: random ±1 codes in both banks, bank switching inside pairs
    for (int r = 0; r < 16; r++) begin
      wr(7 + r, (rnd() & 8'hAA) | 8'h55);
      wr(23 + r, (rnd() & 8'hAA) | 8'h55);
    end
    for (int i = 0; i < 200; i++) begin
      if (i % 50 == 0) wr(40, (i / 50) & 3);
      push((rnd() % 8) - 4, rnd() & 1, "R5");
    end
    wr(39, 1);
    for (int i = 0; i < 80; i++) push((rnd() % 8) - 4, rnd() & 1, "R5");

    // R8 / R9: saturation at both extremes, all window shifts
    wr(39, 0);
    for (int r = 0; r < 16; r++) wr(7 + r, 8'hFF);
    for (int i = 0; i < 128; i++) push(-4, 0, "R8");
    for (int n = 0; n < 4; n++) begin
      wr(40, n);
      push(-4, 0, "R8"); push(-4, 0, "R8");
      chk($signed(corr_full) == 511, "R8", "positive clamp", int'($signed(corr_full)), 511);
    end
    for (int r = 0; r < 16; r++) wr(7 + r, 8'h55);
    for (int i = 0; i < 128; i++) push(-4, 0, "R8");
    for (int n = 0; n < 4; n++) begin
      wr(40, n);
      push(-4, 0, "R8"); push(-4, 0, "R8");
      chk($signed(corr_full) == -512, "R8", "negative full scale", int'($signed(corr_full)), -512);
    end
    for (int r = 0; r < 16; r++) wr(7 + r, 8'h55);
    for (int i = 0; i < 128; i++) push(3, 0, "R8");

    // R10: 13-chip code, taps 13..63 zero (mixed zero codes 00 and 10)
    clear_banks();
    wr(39, 1); wr(40, 1);
    wr(7, 8'hDD); wr(8, 8'h77); wr(9, 8'h5D); wr(10, 8'hA3);
    for (int r = 4; r < 16; r++) wr(7 + r, 8'hAA);
    for (int i = 0; i < 90; i++) push((rnd() % 8) - 4, 0, "R10");
    for (int i = 0; i < 20; i++) push(3, 0, "R10");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule